// File: doc/BRIEF.md
# Power State Controller with Turn-On Hold-off

This block is the supervisory state machine of a power-management device. It keeps the device in one of four states: OFF, a turn-on ramp, ACTIVE and SLEEP. It drives a regulator-enable output and an active-low reset output toward the rest of the system. A power-hold pin turns the device on and off. A sleep pin, together with a sleep-enable control bit, parks the running device in SLEEP. A write port holds two control bits: a self-clearing software turn-off command and the sleep enable.

After each turn-on from OFF, the reset output is released and a minimum-on-time window starts. Until that window expires, a falling power-hold pin cannot shut the device down. Once the window has expired, a falling edge on the pin turns the device off at once. SLEEP does not restart the window. Every pass through OFF restarts it, including an OFF caused by the software command. The window length is a parameter, so the same RTL serves silicon-scale times and short simulations.

Top module: `pwr_state_ctl`

## Requirements
- R1: While the synchronous active-low reset is low, and on the first cycle after it, the controller is in OFF (pwrState 0) with regEnable low, resetN low and timerExpired low. Both control bits read as cleared.
- R2: In OFF, a rising edge on holdPin moves the controller to the ramp state (pwrState 1) three cycles after the pin change, with regEnable high and resetN low. After exactly RAMP_CYCLES cycles in the ramp state, it enters ACTIVE (pwrState 2) with resetN high.
- R3: timerExpired stays low for HOLDOFF_CYCLES cycles after entry to ACTIVE from the ramp state. It goes high on the cycle after that and stays high until the controller next reaches OFF.
- R4: A falling edge on holdPin is ignored while timerExpired is low; it does not take effect later. Once the window has expired, a falling edge moves ACTIVE or SLEEP to OFF three cycles after the pin change.
- R5: A write with wrData bit 0 set moves any on state (ramp, ACTIVE or SLEEP) to OFF two cycles after the write. The bit clears itself, so the next turn-on stays on.
- R6: Every return to ACTIVE through OFF restarts the hold-off window. This holds whether OFF was reached from ACTIVE, from SLEEP or by the software command.
- R7: SLEEP (pwrState 3) is entered from ACTIVE only when the sleep-enable bit is 1 and sleepPin is at its active level (high by default). The sleep-enable bit is latched from wrData bit 1 on every write. The state changes two cycles after the enabling write, or three cycles after the pin change. With the bit at 0, SLEEP is never entered.
- R8: SLEEP returns to ACTIVE three cycles after sleepPin leaves its active level. Neither direction restarts the hold-off timer, which keeps counting through SLEEP.
- R9: In SLEEP, regEnable and resetN both stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| holdPin | input | 1 | Asynchronous power-hold pin |
| sleepPin | input | 1 | Asynchronous sleep request pin |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 2 | Bit 0 software turn-off, bit 1 sleep enable |
| regEnable | output | 1 | Regulator enable |
| resetN | output | 1 | Active-low system reset |
| timerExpired | output | 1 | Hold-off window has expired |
| pwrState | output | 2 | Current state: 0 OFF, 1 ramp, 2 ACTIVE, 3 SLEEP |

## Verification
Each pin reaches the state register three clock edges after it changes: two synchroniser flops, then the state flop. A control write reaches it two edges after it is made: the control register, then the state flop. The hold-off flag rises exactly HOLDOFF_CYCLES edges after ACTIVE is entered. The bench drives inputs on falling edges and samples outputs on falling edges, counted from the drive. It also samples one cycle before each due time to confirm that nothing moves early. A sweep drops the power-hold pin at every offset from the start of ACTIVE through to past expiry. The boundary lies between offset HOLDOFF_CYCLES-3, which is ignored, and HOLDOFF_CYCLES-2, which turns the device off.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_RAMP   = 2'd1,
    PS_ACTIVE = 2'd2,
    PS_SLEEP  = 2'd3
  } pwrState_e;

  localparam int CTL_W   = 2;
  localparam int OFF_BIT = 0;
  localparam int SLP_BIT = 1;

  // control -> datapath
  typedef struct packed {
    logic rampStart;
    logic holdStart;
    logic holdKill;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic holdRise;
    logic holdFall;
    logic sleepAct;
    logic sleepEn;
    logic offReq;
    logic rampDone;
    logic expired;
  } dpStatus_t;

endpackage

// File: rtl/pwr_state_sync.sv
module pwr_state_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= RESET_VAL;
    else       stage[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[i] <= RESET_VAL;
      else       stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pwr_state_dp.sv
module pwr_state_dp
  import pwr_state_pkg::*;
#(
  parameter int   HOLDOFF_CYCLES = 98_400_000,
  parameter int   RAMP_CYCLES    = 1000,
  parameter int   SYNC_STAGES    = 2,
  parameter logic SLEEP_ACTIVE   = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdPin,
  input  logic             sleepPin,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  ctlStrobe_t       strb,
  output dpStatus_t        stat
);
  localparam int HW = $clog2(HOLDOFF_CYCLES + 1);
  localparam int RW = $clog2(RAMP_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LIMIT = HW'(HOLDOFF_CYCLES);
  localparam logic [RW-1:0] RAMP_LAST  = RW'(RAMP_CYCLES - 1);

  logic holdSync, holdPrev, sleepSync;
  logic offReq, sleepEn;
  logic [HW-1:0] holdCnt;
  logic holdArmed;
  logic [RW-1:0] rampCnt;

  pwr_state_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) holdSync_i (
    .clk(clk), .rstN(rstN), .din(holdPin), .dout(holdSync));

  pwr_state_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(~SLEEP_ACTIVE)) sleepSync_i (
    .clk(clk), .rstN(rstN), .din(sleepPin), .dout(sleepSync));

  always_ff @(posedge clk) begin
    if (!rstN) holdPrev <= 1'b0;
    else       holdPrev <= holdSync;
  end

  // control bits: turn-off is a one-cycle self-clearing pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReq  <= 1'b0;
      sleepEn <= 1'b0;
    end else begin
      offReq <= wrEn & wrData[OFF_BIT];
      if (wrEn) sleepEn <= wrData[SLP_BIT];
    end
  end

  // hold-off window counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdArmed <= 1'b0;
      holdCnt   <= '0;
    end else if (strb.holdKill) begin
      holdArmed <= 1'b0;
      holdCnt   <= '0;
    end else if (strb.holdStart) begin
      holdArmed <= 1'b1;
      holdCnt   <= '0;
    end else if (holdArmed && holdCnt != HOLD_LIMIT) begin
      holdCnt <= holdCnt + HW'(1);
    end
  end

  // turn-on ramp counter
  always_ff @(posedge clk) begin
    if (!rstN)                     rampCnt <= '0;
    else if (strb.rampStart)       rampCnt <= '0;
    else if (rampCnt != RAMP_LAST) rampCnt <= rampCnt + RW'(1);
  end

  always_comb begin
    stat.holdRise = holdSync & ~holdPrev;
    stat.holdFall = ~holdSync & holdPrev;
    stat.sleepAct = (sleepSync == SLEEP_ACTIVE);
    stat.sleepEn  = sleepEn;
    stat.offReq   = offReq;
    stat.rampDone = (rampCnt == RAMP_LAST);
    stat.expired  = holdArmed && (holdCnt == HOLD_LIMIT);
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_state_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  stat,
  output ctlStrobe_t strb,
  output pwrState_e  state
);
  pwrState_e nextState;
  logic      offCond;

  assign offCond = stat.offReq || (stat.expired && stat.holdFall);

  always_comb begin
    nextState = state;
    unique case (state)
      PS_OFF:    if (stat.holdRise) nextState = PS_RAMP;
      PS_RAMP:   if (stat.offReq) nextState = PS_OFF;
                 else if (stat.rampDone) nextState = PS_ACTIVE;
      PS_ACTIVE: if (offCond) nextState = PS_OFF;
                 else if (stat.sleepEn && stat.sleepAct) nextState = PS_SLEEP;
      PS_SLEEP:  if (offCond) nextState = PS_OFF;
                 else if (!(stat.sleepEn && stat.sleepAct)) nextState = PS_ACTIVE;
      default:   nextState = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PS_OFF;
    else       state <= nextState;
  end

  always_comb begin
    strb.rampStart = (state == PS_OFF) && (nextState == PS_RAMP);
    strb.holdStart = (state == PS_RAMP) && (nextState == PS_ACTIVE);
    strb.holdKill  = (state != PS_OFF) && (nextState == PS_OFF);
  end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_state_pkg::*;
#(
  parameter int   HOLDOFF_CYCLES = 98_400_000,
  parameter int   RAMP_CYCLES    = 1000,
  parameter int   SYNC_STAGES    = 2,
  parameter logic SLEEP_ACTIVE   = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdPin,
  input  logic             sleepPin,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  output logic             regEnable,
  output logic             resetN,
  output logic             timerExpired,
  output logic [1:0]       pwrState
);
  ctlStrobe_t strb;
  dpStatus_t  dpStat;
  pwrState_e  state;

  pwr_state_dp #(
    .HOLDOFF_CYCLES(HOLDOFF_CYCLES), .RAMP_CYCLES(RAMP_CYCLES),
    .SYNC_STAGES(SYNC_STAGES), .SLEEP_ACTIVE(SLEEP_ACTIVE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .holdPin(holdPin), .sleepPin(sleepPin),
    .wrEn(wrEn), .wrData(wrData), .strb(strb), .stat(dpStat));

  pwr_state_fsm fsm_i (
    .clk(clk), .rstN(rstN), .stat(dpStat), .strb(strb), .state(state));

  assign regEnable    = (state != PS_OFF);
  assign resetN       = (state == PS_ACTIVE) || (state == PS_SLEEP);
  assign timerExpired = dpStat.expired;
  assign pwrState     = state;
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regEnable,
  input logic       resetN,
  input logic       timerExpired,
  input logic [1:0] pwrState,
  input logic       chkOffReq,
  input logic       chkSleepEn
);
  // R1: reset lands in OFF with everything deasserted
  a_r1_reset_off: assert property (@(posedge clk)
    !rstN |=> (pwrState == 2'd0 && !regEnable && !resetN && !timerExpired));

  // R2: reset may only be released while regulators are enabled
  a_r2_reset_needs_supply: assert property (@(posedge clk) disable iff (!rstN)
    resetN |-> regEnable);

  // R2: OFF can only be left for the ramp state
  a_r2_off_to_ramp: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd0 |=> (pwrState == 2'd0 || pwrState == 2'd1));

  // R4: no hold-driven shutdown of ACTIVE before expiry
  a_r4_no_early_off: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 && !timerExpired && !chkOffReq) |=> pwrState != 2'd0);

  // R6: window starts unexpired on each entry to ACTIVE from the ramp
  a_r6_window_restart: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1) |=> !timerExpired);

  // R7: no SLEEP entry without the enable bit
  a_r7_sleep_gated: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2 && !chkSleepEn) |=> pwrState != 2'd3);

  // R8: leaving SLEEP keeps an expired window expired
  a_r8_sleep_keeps_timer: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd3 && timerExpired) |=> (timerExpired || pwrState == 2'd0));
endmodule

bind pwr_state_ctl pwr_state_chk chk_i (
  .clk(clk), .rstN(rstN), .regEnable(regEnable), .resetN(resetN),
  .timerExpired(timerExpired), .pwrState(pwrState),
  .chkOffReq(dpStat.offReq), .chkSleepEn(dpStat.sleepEn));

// File: tb/pwr_state_ctl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctl_tb_top;
  localparam int H = 20;
  localparam int R = 4;
  localparam int OFF = 0, RAMP = 1, ACT = 2, SLP = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdPin = 1'b0, sleepPin = 1'b0, wrEn = 1'b0;
  logic [1:0] wrData = 2'b00;
  logic regEnable, resetN, timerExpired;
  logic [1:0] pwrState;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwr_state_ctl #(.HOLDOFF_CYCLES(H), .RAMP_CYCLES(R)) dut_i (
    .clk(clk), .rstN(rstN), .holdPin(holdPin), .sleepPin(sleepPin),
    .wrEn(wrEn), .wrData(wrData), .regEnable(regEnable), .resetN(resetN),
    .timerExpired(timerExpired), .pwrState(pwrState));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic powerOn();
    holdPin = 1'b0; tick(3);
    holdPin = 1'b1; tick(3 + R);
  endtask

  task automatic swOff(input logic keepSleep);
    wrEn = 1'b1; wrData = {keepSleep, 1'b1}; tick(1);
    wrEn = 1'b0; wrData = 2'b00; tick(1);
  endtask

  task automatic writeSleepEn(input logic en);
    wrEn = 1'b1; wrData = {en, 1'b0}; tick(1);
    wrEn = 1'b0; wrData = 2'b00; tick(1);
  endtask

  initial begin
    tick(1);
    // R1 reset state
    chk("R1 state", pwrState, OFF);
    chk("R1 regEnable", regEnable, 0);
    chk("R1 resetN", resetN, 0);
    chk("R1 expired", timerExpired, 0);
    tick(2);
    rstN = 1'b1;
    tick(1);
    chk("R1 state after release", pwrState, OFF);

    // R2 turn-on sequence timing
    holdPin = 1'b1; tick(2);
    chk("R2 not yet on", pwrState, OFF);
    tick(1);
    chk("R2 ramp state", pwrState, RAMP);
    chk("R2 ramp regEnable", regEnable, 1);
    chk("R2 ramp resetN", resetN, 0);
    tick(R - 1);
    chk("R2 ramp length", pwrState, RAMP);
    tick(1);
    chk("R2 active", pwrState, ACT);
    chk("R2 resetN released", resetN, 1);

    // R3 exact window
    chk("R3 expired at entry", timerExpired, 0);
    tick(H - 1);
    chk("R3 expired one early", timerExpired, 0);
    tick(1);
    chk("R3 expired on time", timerExpired, 1);
    tick(5);
    chk("R3 expired stays", timerExpired, 1);

    // R4 sweep of the hold drop offset
    for (int d = 0; d <= H + 1; d++) begin
      swOff(1'b0);
      powerOn();
      tick(d);
      holdPin = 1'b0;
      tick(3);
      chk("R4 drop sweep", pwrState, (d >= H - 2) ? OFF : ACT);
      if (d < H - 2) begin
        tick(H + 2);
        chk("R4 ignored drop not remembered", pwrState, ACT);
      end
    end

    // R5 software off and self-clear, R6 restart
    powerOn();
    tick(H + 2);
    chk("R5 before write", pwrState, ACT);
    wrEn = 1'b1; wrData = 2'b01; tick(1);
    wrEn = 1'b0; wrData = 2'b00;
    chk("R5 one cycle after write", pwrState, ACT);
    tick(1);
    chk("R5 off after write", pwrState, OFF);
    chk("R5 regEnable off", regEnable, 0);
    powerOn();
    chk("R6 window restarted after sw off", timerExpired, 0);
    tick(H + 5);
    chk("R5 bit self-cleared", pwrState, ACT);

    // R7 sleep gating
    sleepPin = 1'b1; tick(8);
    chk("R7 no sleep without enable", pwrState, ACT);
    wrEn = 1'b1; wrData = 2'b10; tick(1);
    wrEn = 1'b0; wrData = 2'b00;
    chk("R7 sleep one cycle after write", pwrState, ACT);
    tick(1);
    chk("R7 sleep entered", pwrState, SLP);
    chk("R9 sleep regEnable", regEnable, 1);
    chk("R9 sleep resetN", resetN, 1);
    chk("R8 expired kept in sleep", timerExpired, 1);

    // R8 sleep exit timing
    sleepPin = 1'b0; tick(2);
    chk("R8 still sleep", pwrState, SLP);
    tick(1);
    chk("R8 back to active", pwrState, ACT);
    chk("R8 expired kept on exit", timerExpired, 1);

    // R8 timer counts through sleep
    swOff(1'b1);
    sleepPin = 1'b1;
    powerOn();
    chk("R6 window restarted", timerExpired, 0);
    tick(1);
    chk("R7 sleep from pin", pwrState, SLP);
    tick(H - 2);
    chk("R8 expired one early in sleep", timerExpired, 0);
    tick(1);
    chk("R8 expired on time in sleep", timerExpired, 1);
    sleepPin = 1'b0; tick(3);
    chk("R8 wake", pwrState, ACT);
    sleepPin = 1'b1; tick(3);
    chk("R7 sleep again", pwrState, SLP);

    // R4 hold drop from sleep after expiry
    holdPin = 1'b0; tick(2);
    chk("R4 sleep hold drop pending", pwrState, SLP);
    tick(1);
    chk("R4 off from sleep", pwrState, OFF);

    // R6 restart after sleep path, R4 early drop in sleep ignored
    powerOn();
    chk("R6 restart after sleep off", timerExpired, 0);
    tick(1);
    holdPin = 1'b0; tick(3);
    chk("R4 early drop in sleep ignored", pwrState, SLP);

    // R5 software off from sleep
    swOff(1'b1);
    chk("R5 off from sleep", pwrState, OFF);
    powerOn();
    chk("R6 restart after sw off from sleep", timerExpired, 0);
    tick(4);
    chk("R5 stays on after sleep off", regEnable, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule